// File: doc/BRIEF.md
# Descriptor Ring Receive DMA Engine

This block is a bus-master DMA engine that drains a receive FIFO into memory. The FIFO sits at a fixed local address, so the source address never moves. The memory destination advances one 32-bit word at a time. The engine walks a linked list of descriptors kept in memory. Software builds that list as a closed ring, so once it is started the engine keeps filling buffers until it is aborted.

Software first writes the address of the first descriptor, together with its flag bits, into the pointer register. It then issues a control write with enable and start set. Words move only while the FIFO signals that data is available (demand pacing), and back-to-back words are allowed when memory acknowledges at once. When a descriptor is finished, the engine raises a sticky interrupt if that descriptor asks for one. It then follows the descriptor's next pointer. Software learns which buffers are full by reading the current destination address.

Top module: `ring_dma_engine`

## Requirements
- R1: After synchronous reset `busy`, `irq`, `err`, `mem_req` and `fifo_rd` are 0 and `cur_addr` is 0.
- R2: A control write with `ctl_enable`=1 and `ctl_start`=1 while idle fetches four 32-bit words from the descriptor at (pointer & ~0xF), at offsets 0, 4, 8 and 12. Offset 0 is the destination start address, offset 4 is the local source (unused, the source is the fixed FIFO), offset 8 is the byte count and offset 12 is the next pointer. `cur_addr` then equals the destination start. A start while busy is ignored.
- R3: Pointer flag bits: bit 0 means the descriptor is in host memory, bit 2 means interrupt on terminal count, bit 3 means the direction is local-to-host. A started or fetched pointer with bit 0 or bit 3 clear sets `err` and leaves the engine idle, with no data transfer.
- R4: A byte count that is zero, not a multiple of 4, or above `MAX_XFER_BYTES` (default 65536) sets `err` and returns the engine to idle before any data moves. A later start clears `err`.
- R5: `fifo_rd` is asserted only while `fifo_ready` is 1 (demand pacing). Every popped word is written to memory, in pop order, with its FIFO value.
- R6: The first data write of a descriptor goes to its destination start address, and each later write goes 4 bytes higher.
- R7: After a descriptor's byte count has been written, the engine fetches the descriptor named by its next pointer. A ring whose last descriptor points back to the first is followed endlessly.
- R8: `irq` is set when a descriptor with next-pointer bit 2 set completes. It is not set by a descriptor with bit 2 clear, and it stays set until cleared.
- R9: A control write with `ctl_enable`=1 and `ctl_clear_irq`=1 clears `irq` without stopping the transfer.
- R10: If a terminal-count completion and an interrupt-clear write fall in the same cycle, `irq` stays set.
- R11: A control write with `ctl_enable`=0 aborts. An access already in flight completes, the engine returns to idle, every popped word has been written, and no further requests are made.
- R12: `cur_addr` shows the next destination address. After a completion and the fetch of the next descriptor, it equals that descriptor's start address.
- R13: A memory request keeps `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_enable | input | 1 | Enable value written by a control write |
| ctl_start | input | 1 | Start request, honoured with enable while idle |
| ctl_clear_irq | input | 1 | Interrupt acknowledge |
| ptr_wr | input | 1 | Descriptor pointer write strobe |
| ptr_wdata | input | 32 | First descriptor address with flags in bits 3:0 |
| busy | output | 1 | Engine not idle |
| irq | output | 1 | Sticky terminal-count interrupt |
| err | output | 1 | Sticky descriptor error |
| cur_addr | output | 32 | Current destination address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a data write, 0 for a descriptor read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| fifo_ready | input | 1 | FIFO has a word (demand) |
| fifo_data | input | 32 | FIFO head word |
| fifo_rd | output | 1 | Pop the FIFO head this cycle |

## Verification
Two functions can meet in one cycle: the acknowledge of the last data write of an interrupting descriptor, and a software interrupt-clear write. The bench's memory model watches its own write count. When it acknowledges the final word of such a descriptor, it drives the clear write in that same cycle. `irq` must then read 1 afterwards, showing that the completion wins over the clear. A second overlap is a popped word coinciding with an abort. This is provoked by aborting during random demand and acknowledge traffic, and it is judged by requiring that the number of popped words equals the number of writes once the engine is idle.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_XFER} seq_state_t;
  localparam int WORD_BITS = 32;
  localparam int FLG_HOST  = 0;
  localparam int FLG_TC    = 2;
  localparam int FLG_L2H   = 3;
  localparam int DESC_WORDS = 4;
  localparam logic [1:0] SLOT_DST  = 2'd0;
  localparam logic [1:0] SLOT_SIZE = 2'd2;
  localparam logic [1:0] SLOT_NEXT = 2'd3;
endpackage

// File: rtl/ring_dma_ptr_chk.sv
module ring_dma_ptr_chk
  import ring_dma_pkg::*;
(
  input  logic [WORD_BITS-1:0] ptr,
  output logic                 ptr_ok
);
  assign ptr_ok = ptr[FLG_HOST] & ptr[FLG_L2H];
endmodule

// File: rtl/ring_dma_size_chk.sv
module ring_dma_size_chk
  import ring_dma_pkg::*;
#(
  parameter int MAX_XFER_BYTES = 65536
) (
  input  logic [WORD_BITS-1:0] size,
  output logic                 size_ok
);
  assign size_ok = (size != '0) && (size[1:0] == 2'b00) &&
                   (size <= WORD_BITS'(MAX_XFER_BYTES));
endmodule

// File: rtl/ring_dma_csr.sv
module ring_dma_csr
  import ring_dma_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_wr,
  input  logic                 ctl_enable,
  input  logic                 ctl_start,
  input  logic                 ctl_clear_irq,
  input  logic                 ptr_wr,
  input  logic [WORD_BITS-1:0] ptr_wdata,
  input  logic                 irq_evt,
  input  logic                 err_evt,
  output logic                 enable_q,
  output logic                 start_pulse,
  output logic                 irq_q,
  output logic                 err_q,
  output logic [WORD_BITS-1:0] ptr_q
);
  assign start_pulse = ctl_wr & ctl_enable & ctl_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= 1'b0;
      irq_q    <= 1'b0;
      err_q    <= 1'b0;
      ptr_q    <= '0;
    end else begin
      if (ctl_wr) enable_q <= ctl_enable;
      if (ptr_wr) ptr_q <= ptr_wdata;
      // a completion in the same cycle as an acknowledge keeps the flag
      if (irq_evt)                         irq_q <= 1'b1;
      else if (ctl_wr && ctl_clear_irq)    irq_q <= 1'b0;
      if (err_evt)          err_q <= 1'b1;
      else if (start_pulse) err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_dma_seq.sv
module ring_dma_seq
  import ring_dma_pkg::*;
#(
  parameter int MAX_XFER_BYTES = 65536
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 start,
  input  logic [WORD_BITS-1:0] ptr_cfg,
  input  logic                 fifo_ready,
  input  logic [WORD_BITS-1:0] fifo_data,
  output logic                 fifo_rd,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [WORD_BITS-1:0] mem_addr,
  output logic [WORD_BITS-1:0] mem_wdata,
  input  logic                 mem_ack,
  input  logic [WORD_BITS-1:0] mem_rdata,
  output logic [WORD_BITS-1:0] cur_addr,
  output logic                 busy,
  output logic                 tc_evt,
  output logic                 irq_evt,
  output logic                 err_evt,
  output logic                 wr_mid
);
  localparam int RW = $clog2(MAX_XFER_BYTES) + 1;
  localparam int PW = WORD_BITS - 4;

  seq_state_t           state;
  logic [1:0]           slot;
  logic [PW-1:0]        dptr;
  logic [WORD_BITS-1:0] cur_q, size_q, nxt_q, wbuf;
  logic [RW-1:0]        rem_q;
  logic                 wpend;

  logic start_ptr_ok, next_ptr_ok, size_ok;
  logic fetch_ack, fetch_last, wr_ack, last_word, desc_bad;

  ring_dma_ptr_chk u_ptr_start (.ptr(ptr_cfg),   .ptr_ok(start_ptr_ok));
  ring_dma_ptr_chk u_ptr_next  (.ptr(mem_rdata), .ptr_ok(next_ptr_ok));
  ring_dma_size_chk #(.MAX_XFER_BYTES(MAX_XFER_BYTES)) u_size (
    .size(size_q), .size_ok(size_ok));

  assign fetch_ack  = (state == ST_FETCH) & mem_ack;
  assign fetch_last = fetch_ack & (slot == SLOT_NEXT);
  assign desc_bad   = ~(size_ok & next_ptr_ok);
  assign wr_ack     = (state == ST_XFER) & wpend & mem_ack;
  assign last_word  = (rem_q == RW'(4));

  assign fifo_rd = (state == ST_XFER) & enable & fifo_ready &
                   (~wpend | (wr_ack & ~last_word));
  assign tc_evt  = wr_ack & last_word;
  assign irq_evt = tc_evt & nxt_q[FLG_TC];
  assign wr_mid  = wr_ack & ~last_word;
  assign err_evt = (start & (state == ST_IDLE) & ~start_ptr_ok) |
                   (fetch_last & desc_bad);

  assign mem_req   = (state == ST_FETCH) | ((state == ST_XFER) & wpend);
  assign mem_we    = (state == ST_XFER);
  assign mem_addr  = (state == ST_FETCH) ? {dptr, slot, 2'b00} : cur_q;
  assign mem_wdata = wbuf;
  assign cur_addr  = cur_q;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      slot   <= '0;
      dptr   <= '0;
      cur_q  <= '0;
      size_q <= '0;
      nxt_q  <= '0;
      wbuf   <= '0;
      rem_q  <= '0;
      wpend  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          wpend <= 1'b0;
          if (start && start_ptr_ok) begin
            dptr  <= ptr_cfg[WORD_BITS-1:4];
            slot  <= '0;
            state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            case (slot)
              SLOT_DST:  cur_q  <= mem_rdata;
              SLOT_SIZE: size_q <= mem_rdata;
              SLOT_NEXT: nxt_q  <= mem_rdata;
              default: ;
            endcase
            slot <= slot + 2'd1;
            if (slot == SLOT_NEXT) begin
              if (desc_bad || !enable) state <= ST_IDLE;
              else begin
                rem_q <= size_q[RW-1:0];
                state <= ST_XFER;
              end
            end else if (!enable) begin
              state <= ST_IDLE;
            end
          end
        end
        ST_XFER: begin
          if (wr_ack) begin
            cur_q <= cur_q + WORD_BITS'(4);
            rem_q <= rem_q - RW'(4);
            wpend <= 1'b0;
            if (last_word) begin
              dptr  <= nxt_q[WORD_BITS-1:4];
              slot  <= '0;
              state <= enable ? ST_FETCH : ST_IDLE;
            end
          end else if (!wpend && !enable) begin
            state <= ST_IDLE;
          end
          if (fifo_rd) begin
            wbuf  <= fifo_data;
            wpend <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_dma_engine.sv
module ring_dma_engine
  import ring_dma_pkg::*;
#(
  parameter int MAX_XFER_BYTES = 65536
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_wr,
  input  logic        ctl_enable,
  input  logic        ctl_start,
  input  logic        ctl_clear_irq,
  input  logic        ptr_wr,
  input  logic [31:0] ptr_wdata,
  output logic        busy,
  output logic        irq,
  output logic        err,
  output logic [31:0] cur_addr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        fifo_ready,
  input  logic [31:0] fifo_data,
  output logic        fifo_rd
);
  logic enable_q, start_pulse, irq_evt, err_evt, tc_evt, wr_mid;
  logic [WORD_BITS-1:0] ptr_q;

  ring_dma_csr u_csr (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_enable(ctl_enable),
    .ctl_start(ctl_start), .ctl_clear_irq(ctl_clear_irq),
    .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
    .irq_evt(irq_evt), .err_evt(err_evt),
    .enable_q(enable_q), .start_pulse(start_pulse),
    .irq_q(irq), .err_q(err), .ptr_q(ptr_q));

  ring_dma_seq #(.MAX_XFER_BYTES(MAX_XFER_BYTES)) u_seq (
    .clk(clk), .rst(rst), .enable(enable_q), .start(start_pulse),
    .ptr_cfg(ptr_q), .fifo_ready(fifo_ready), .fifo_data(fifo_data),
    .fifo_rd(fifo_rd), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .cur_addr(cur_addr), .busy(busy),
    .tc_evt(tc_evt), .irq_evt(irq_evt), .err_evt(err_evt), .wr_mid(wr_mid));
endmodule

// File: rtl/ring_dma_engine_chk.sv
module ring_dma_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        irq,
  input logic        err,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] cur_addr,
  input logic        fifo_rd,
  input logic        fifo_ready,
  input logic        ctl_wr,
  input logic        ctl_clear_irq,
  input logic        irq_evt,
  input logic        wr_mid
);
  assert_pop_on_demand_R5: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> fifo_ready);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
    wr_mid |=> cur_addr == $past(cur_addr) + 32'd4);

  assert_tc_sets_irq_R8: assert property (@(posedge clk) disable iff (rst)
    irq_evt |=> irq);

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (irq && !(ctl_wr && ctl_clear_irq)) |=> irq);

  assert_tc_beats_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_evt && ctl_wr && ctl_clear_irq) |=> irq);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !fifo_rd));

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

bind ring_dma_engine ring_dma_engine_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .irq(irq), .err(err),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_addr(cur_addr),
  .fifo_rd(fifo_rd), .fifo_ready(fifo_ready), .ctl_wr(ctl_wr),
  .ctl_clear_irq(ctl_clear_irq), .irq_evt(irq_evt), .wr_mid(wr_mid));

// File: tb/ring_dma_engine_bench.sv
module ring_dma_engine_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        tb_wr = 0, tb_en = 0, tb_st = 0, tb_clr = 0;
  logic        coin_clr = 0;
  logic        ptr_wr = 0;
  logic [31:0] ptr_wdata = 0;
  logic        busy, irq, err, mem_req, mem_we, mem_ack, fifo_rd;
  logic [31:0] cur_addr, mem_addr, mem_wdata, mem_rdata;
  logic        ctl_wr, ctl_enable, ctl_clear_irq;

  int tokens = 0;
  logic rdy_gate = 1'b1;
  logic fifo_ready;
  logic [31:0] fifo_cnt = 0;

  assign ctl_wr        = tb_wr | coin_clr;
  assign ctl_enable    = tb_en | coin_clr;
  assign ctl_clear_irq = tb_clr | coin_clr;
  assign fifo_ready    = (tokens > 0) && rdy_gate;

  ring_dma_engine u_ring_dma_engine (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_enable(ctl_enable),
    .ctl_start(tb_st), .ctl_clear_irq(ctl_clear_irq), .ptr_wr(ptr_wr),
    .ptr_wdata(ptr_wdata), .busy(busy), .irq(irq), .err(err),
    .cur_addr(cur_addr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .fifo_ready(fifo_ready), .fifo_data(fifo_cnt),
    .fifo_rd(fifo_rd));

  // ring description used to compute expected writes
  logic [31:0] dbuf  [3] = '{32'h1000, 32'h2000, 32'h3000};
  int          dsize [3] = '{2, 3, 1};
  logic        dtc   [3] = '{1'b1, 1'b0, 1'b1};

  logic [31:0] mem [4096];
  int n_chk = 0, n_err = 0, m_chk = 0, m_err = 0;
  int wd = 0, wo = 0;
  logic [31:0] wr_total = 0;
  logic coin_mode = 0, coin_seen = 0;
  logic random_ack = 1;

  function automatic logic [31:0] exp_addr(int d, int o);
    return dbuf[d] + 32'(o * 4);
  endfunction

  always @(posedge clk) if (fifo_rd) begin
    fifo_cnt <= fifo_cnt + 1;
    tokens   <= tokens - 1;
  end

  // memory model and write checker (R5 R6 R7)
  always @(negedge clk) begin
    logic ack;
    coin_clr = 1'b0;
    ack = random_ack ? (($urandom % 4) != 0) : 1'b1;
    if (!rdy_gate || tokens > 100) rdy_gate = ($urandom % 3) != 0;
    mem_ack = mem_req && ack;
    if (mem_req && ack) begin
      if (mem_we) begin
        m_chk++;
        if (mem_addr !== exp_addr(wd, wo) || mem_wdata !== wr_total) begin
          m_err++;
          $display("FAIL R5/R6/R7 write: addr %h data %h expected addr %h data %h",
                   mem_addr, mem_wdata, exp_addr(wd, wo), wr_total);
        end
        mem[mem_addr[13:2]] = mem_wdata;
        if (coin_mode && dtc[wd] && (wo + 1 == dsize[wd])) begin
          coin_clr = 1'b1;
          coin_seen = 1'b1;
        end
        wr_total++;
        wo++;
        if (wo == dsize[wd]) begin
          wo = 0;
          wd = (wd + 1) % 3;
        end
      end else begin
        mem_rdata = mem[mem_addr[13:2]];
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ctl(input logic en, input logic st, input logic clr);
    @(negedge clk);
    tb_wr = 1; tb_en = en; tb_st = st; tb_clr = clr;
    @(negedge clk);
    tb_wr = 0; tb_en = 0; tb_st = 0; tb_clr = 0;
  endtask

  task automatic set_ptr(input logic [31:0] p);
    @(negedge clk);
    ptr_wr = 1; ptr_wdata = p;
    @(negedge clk);
    ptr_wr = 0;
  endtask

  task automatic put_desc(input int base, input logic [31:0] dst,
                          input logic [31:0] sz, input logic [31:0] nxt);
    mem[base/4]   = dst;
    mem[base/4+1] = 32'h18;
    mem[base/4+2] = sz;
    mem[base/4+3] = nxt;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk + m_chk, n_err + m_err);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] saved, saved_pop;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    mem_ack = 0; mem_rdata = 0;
    // flags 4'b1101: host, tc irq, local-to-host; 4'b1001: no irq
    put_desc(32'h100, 32'h1000, 32'd8,  32'h110 | 32'hD);
    put_desc(32'h110, 32'h2000, 32'd12, 32'h120 | 32'h9);
    put_desc(32'h120, 32'h3000, 32'd4,  32'h100 | 32'hD);
    put_desc(32'h200, 32'h3800, 32'd6,  32'h200 | 32'h9);
    put_desc(32'h220, 32'h3800, 32'd0,  32'h220 | 32'h9);
    put_desc(32'h240, 32'h3800, 32'h10004, 32'h240 | 32'h9);
    cycles(4);
    rst = 0;
    cycles(1);
    // R1
    check(!busy && !irq && !err && !mem_req && !fifo_rd && cur_addr == 0,
          "R1 reset state", {busy, irq, err, mem_req, cur_addr[27:0]}, 0);

    // R3: direction flag clear
    set_ptr(32'h100 | 32'h5);
    ctl(1, 1, 0);
    cycles(6);
    check(err && !busy, "R3 bad flags sets err", {err, busy}, 2'b10);
    check(wr_total == 0, "R3 no transfer", wr_total, 0);

    // R4: bad byte counts
    set_ptr(32'h200 | 32'h9);
    ctl(1, 1, 0);
    cycles(40);
    check(err && !busy, "R4 size 6 rejected", {err, busy}, 2'b10);
    set_ptr(32'h220 | 32'h9);
    ctl(1, 1, 0);
    cycles(40);
    check(err && !busy, "R4 size 0 rejected", {err, busy}, 2'b10);
    set_ptr(32'h240 | 32'h9);
    ctl(1, 1, 0);
    cycles(40);
    check(err && !busy && wr_total == 0, "R4 oversize rejected", {err, busy}, 2'b10);

    // R2/R5: start ring with no FIFO data
    set_ptr(32'h100 | 32'hD);
    ctl(1, 1, 0);
    cycles(40);
    check(busy && !err, "R2/R4 started, err cleared", {busy, err}, 2'b10);
    check(cur_addr == 32'h1000, "R2 destination loaded", cur_addr, 32'h1000);
    check(wr_total == 0 && fifo_cnt == 0, "R5 no pop without demand", fifo_cnt, 0);
    ctl(1, 1, 0);
    cycles(4);
    check(busy && cur_addr == 32'h1000, "R2 start while busy ignored", cur_addr, 32'h1000);

    // R8/R12: first descriptor (irq flag)
    tokens = 2;
    cycles(60);
    check(irq == 1, "R8 irq after tc descriptor", irq, 1);
    check(cur_addr == 32'h2000, "R12 next buffer start", cur_addr, 32'h2000);
    check(wr_total == 2, "R6 two words", wr_total, 2);

    // R9
    ctl(1, 0, 1);
    cycles(1);
    check(!irq && busy, "R9 clear keeps running", {irq, busy}, 2'b01);
    tokens = 3;
    cycles(60);
    check(irq == 0, "R8 no irq without flag", irq, 0);
    check(cur_addr == 32'h3000, "R12 third buffer", cur_addr, 32'h3000);

    // R7: wrap
    tokens = 1;
    cycles(60);
    check(irq == 1, "R8 irq third descriptor", irq, 1);
    check(cur_addr == 32'h1000, "R7 ring wraps", cur_addr, 32'h1000);
    ctl(1, 0, 1);

    // R10: clear in completion cycle
    coin_mode = 1;
    tokens = 2;
    cycles(60);
    coin_mode = 0;
    check(coin_seen, "R10 coincidence provoked", coin_seen, 1);
    check(irq == 1, "R10 tc wins over clear", irq, 1);
    ctl(1, 0, 1);

    // random demand and acknowledge traffic
    saved = wr_total;
    tokens = 40;
    rdy_gate = 0;
    for (int i = 0; i < 3000 && tokens != 0; i++) @(negedge clk);
    cycles(40);
    rdy_gate = 1;
    check(wr_total == saved + 40, "R5 all random words written", wr_total, saved + 40);

    // R11: abort mid-stream
    tokens = 1000;
    rdy_gate = 0;
    cycles(7 + ($urandom % 5));
    ctl(0, 0, 0);
    cycles(30);
    check(!busy && !mem_req, "R11 idle after abort", {busy, mem_req}, 0);
    check(fifo_cnt == wr_total, "R11 popped words written", wr_total, fifo_cnt);
    saved = wr_total;
    saved_pop = fifo_cnt;
    cycles(20);
    check(wr_total == saved && fifo_cnt == saved_pop, "R11 no activity after abort",
          wr_total, saved);
    tokens = 0;
    rdy_gate = 1;
    finish_run();
  end
endmodule